// File: doc/BRIEF.md
# Command/Reply Serial Master

This block is a half-duplex serial master for slaves that take a command and then answer it. A host writes 8-bit command bytes into a transmit queue. For each byte, the block pulls an active-low frame select low and shifts the byte out MSB first on the data output. It then leaves one serial clock period idle so the slave can decode the command. After that it clocks in a reply of 4 to 16 bits, MSB first, on the separate data input and stores the reply word in a receive queue.

The serial clock comes from the system clock through a programmable divider. It runs only inside a frame. In single mode every frame ends with frame select going high. In continuous mode the next queued command follows the reply LSB directly, and frame select stays low. The divider value, the reply width and the mode are captured when a frame starts from idle.

Top module: `cmd_reply_serial_master`

## Requirements
- R1: While reset is active, `cs_no` is high, `sclk_o`, `sdo_o`, `busy_o` and `overrun_o` are low, both queues report empty, and neither queue reports full.
- R2: When idle with a non-empty transmit queue, `cs_no` falls and the oldest byte is taken. `sclk_o` is low whenever `cs_no` is high. The first rising `sclk_o` edge comes `div_i+1` system clocks after `cs_no` falls. Later rising edges inside a frame are `2*(div_i+1)` system clocks apart.
- R3: The command is 8 bits, sent MSB first, and is valid at each rising `sclk_o` edge. `sdo_o` changes only while `sclk_o` is low or on its falling edge. Commands leave in the order they were queued.
- R4: After the 8th command bit there is exactly one full serial period, with one rising edge, on which nothing is sampled. `sdo_o` is low from then until the command of the next frame. `sdi_i` is ignored during the command and the idle period.
- R5: The reply is sampled on rising `sclk_o` edges, MSB first. Its length is `resp_len_i` clamped to the range 4..16. The stored word is right-aligned, with the upper bits zero.
- R6: In single mode, `cs_no` rises `2*(div_i+1)` system clocks after the rising edge that samples the reply LSB. The word is in the receive queue by the same clock edge.
- R7: In continuous mode with another command queued, `cs_no` stays low. The next command MSB is driven on the falling edge after the reply LSB, and the finished word is queued on that edge. With the transmit queue empty, the frame ends as in R6.
- R8: `busy_o` is high exactly while `cs_no` is low.
- R9: `div_i`, `resp_len_i` and `cont_i` are captured only when a frame starts from idle. Changes during a frame do not affect its timing, its length or how it ends.
- R10: Each queue holds 8 entries and is first-word-fall-through. A push while `tx_full_o` is high is dropped. The full and empty flags track the occupancy.
- R11: A reply word that finishes while the receive queue is full is dropped and sets `overrun_o`. `overrun_o` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_push_i | input | 1 | Write `tx_data_i` into the transmit queue |
| tx_data_i | input | 8 | Command byte |
| tx_full_o | output | 1 | Transmit queue full |
| tx_empty_o | output | 1 | Transmit queue empty |
| rx_pop_i | input | 1 | Remove the head of the receive queue |
| rx_data_o | output | 16 | Head of the receive queue, right-aligned reply |
| rx_full_o | output | 1 | Receive queue full |
| rx_empty_o | output | 1 | Receive queue empty |
| div_i | input | 8 | Serial half-period minus one, in system clocks |
| resp_len_i | input | 5 | Reply width in bits, clamped to 4..16 |
| cont_i | input | 1 | 1 = continuous frames, 0 = single frames |
| sclk_o | output | 1 | Serial clock, idles low |
| cs_no | output | 1 | Frame select, active low |
| sdo_o | output | 1 | Serial command output |
| sdi_i | input | 1 | Serial reply input |
| busy_o | output | 1 | Frame in progress |
| overrun_o | output | 1 | Sticky receive overrun flag |

## Verification
The assertions assume that `sdi_i` and the configuration inputs change only between system clock edges. They also assume that the host sees `rx_pop_i` dropped on an empty queue. The stimulus drives every host input half a cycle away from the active edge. The slave model changes `sdi_i` only after a falling `sclk_o` edge and drives random values during the command and idle periods. Configuration normally changes only while idle. One directed frame changes all three settings mid-frame to show that they are ignored. Random bursts of up to three commands are drained before the next burst starts, so the receive queue overflows only in the directed overrun case.

// File: rtl/crsm_pkg.sv
package crsm_pkg;
  localparam int unsigned CMD_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_WAIT,
    ST_RESP,
    ST_TAIL
  } frame_st_e;
endpackage

// File: rtl/crsm_fifo.sv
module crsm_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + CW'(1);
      else if (do_pop && !do_push) cnt_q <= cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end
endmodule

// File: rtl/crsm_sclk_div.sv
module crsm_sclk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/crsm_frame_ctrl.sv
module crsm_frame_ctrl
  import crsm_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int RESP_MIN = 4,
  parameter int RESP_MAX = 16,
  parameter int LEN_W    = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tx_empty_i,
  input  logic [CMD_W-1:0]    tx_data_i,
  output logic                tx_pop_o,
  input  logic [DIV_W-1:0]    div_cfg_i,
  input  logic [LEN_W-1:0]    len_cfg_i,
  input  logic                cont_cfg_i,
  input  logic                tick_i,
  output logic                run_o,
  output logic [DIV_W-1:0]    div_o,
  input  logic                sdi_i,
  output logic                sclk_o,
  output logic                cs_no,
  output logic                sdo_o,
  output logic                busy_o,
  output logic                rx_push_o,
  output logic [RESP_MAX-1:0] rx_word_o
);
  frame_st_e           st_q;
  logic                sclk_q, cs_q, cont_q;
  logic [CMD_W-1:0]    tx_sh_q;
  logic [RESP_MAX-1:0] rx_sh_q;
  logic [LEN_W-1:0]    cnt_q, len_q, len_clamped;
  logic [DIV_W-1:0]    div_q;
  logic                rise, fall, start, reply_end, chain, tail_done;

  always_comb begin
    if (len_cfg_i < LEN_W'(RESP_MIN))      len_clamped = LEN_W'(RESP_MIN);
    else if (len_cfg_i > LEN_W'(RESP_MAX)) len_clamped = LEN_W'(RESP_MAX);
    else                                   len_clamped = len_cfg_i;
  end

  // the tail half-period keeps sclk low, so a tick there is not a rising edge
  assign rise      = tick_i && !sclk_q && (st_q != ST_TAIL);
  assign fall      = tick_i && sclk_q;
  assign start     = (st_q == ST_IDLE) && !tx_empty_i;
  assign reply_end = fall && (st_q == ST_RESP) && (cnt_q == len_q);
  assign chain     = reply_end && cont_q && !tx_empty_i;
  assign tail_done = tick_i && (st_q == ST_TAIL);

  assign tx_pop_o  = start || chain;
  assign rx_push_o = chain || tail_done;
  assign rx_word_o = rx_sh_q;
  assign run_o     = (st_q != ST_IDLE);
  assign div_o     = div_q;
  assign sclk_o    = sclk_q;
  assign cs_no     = cs_q;
  assign busy_o    = (st_q != ST_IDLE);
  assign sdo_o     = (st_q == ST_CMD) && tx_sh_q[CMD_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      sclk_q  <= 1'b0;
      cs_q    <= 1'b1;
      cont_q  <= 1'b0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
      cnt_q   <= '0;
      len_q   <= LEN_W'(RESP_MIN);
      div_q   <= '0;
    end else begin
      if (rise)      sclk_q <= 1'b1;
      else if (fall) sclk_q <= 1'b0;

      unique case (st_q)
        ST_IDLE: if (start) begin
          st_q    <= ST_CMD;
          cs_q    <= 1'b0;
          tx_sh_q <= tx_data_i;
          cnt_q   <= '0;
          len_q   <= len_clamped;
          div_q   <= div_cfg_i;
          cont_q  <= cont_cfg_i;
        end
        ST_CMD: begin
          if (rise) cnt_q <= cnt_q + LEN_W'(1);
          if (fall) begin
            if (cnt_q == LEN_W'(CMD_W)) begin
              st_q  <= ST_WAIT;
              cnt_q <= '0;
            end else begin
              tx_sh_q <= {tx_sh_q[CMD_W-2:0], 1'b0};
            end
          end
        end
        ST_WAIT: if (fall) begin
          st_q    <= ST_RESP;
          rx_sh_q <= '0;
        end
        ST_RESP: begin
          if (rise) begin
            rx_sh_q <= {rx_sh_q[RESP_MAX-2:0], sdi_i};
            cnt_q   <= cnt_q + LEN_W'(1);
          end
          if (reply_end) begin
            if (chain) begin
              st_q    <= ST_CMD;
              tx_sh_q <= tx_data_i;
              cnt_q   <= '0;
            end else begin
              st_q <= ST_TAIL;
            end
          end
        end
        ST_TAIL: if (tick_i) begin
          st_q <= ST_IDLE;
          cs_q <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmd_reply_serial_master.sv
module cmd_reply_serial_master
  import crsm_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int RESP_MIN   = 4,
  parameter int RESP_MAX   = 16,
  parameter int FIFO_DEPTH = 8,
  localparam int LEN_W     = $clog2(RESP_MAX + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tx_push_i,
  input  logic [CMD_W-1:0]    tx_data_i,
  output logic                tx_full_o,
  output logic                tx_empty_o,
  input  logic                rx_pop_i,
  output logic [RESP_MAX-1:0] rx_data_o,
  output logic                rx_full_o,
  output logic                rx_empty_o,
  input  logic [DIV_W-1:0]    div_i,
  input  logic [LEN_W-1:0]    resp_len_i,
  input  logic                cont_i,
  output logic                sclk_o,
  output logic                cs_no,
  output logic                sdo_o,
  input  logic                sdi_i,
  output logic                busy_o,
  output logic                overrun_o
);
  logic                tx_pop, rx_push, run, tick, ovr_q;
  logic [CMD_W-1:0]    tx_head;
  logic [RESP_MAX-1:0] rx_word;
  logic [DIV_W-1:0]    div_act;

  crsm_fifo #(.W(CMD_W), .DEPTH(FIFO_DEPTH)) i_tx_fifo (
    .clk_i, .rst_ni,
    .push_i (tx_push_i),
    .data_i (tx_data_i),
    .pop_i  (tx_pop),
    .data_o (tx_head),
    .full_o (tx_full_o),
    .empty_o(tx_empty_o)
  );

  crsm_fifo #(.W(RESP_MAX), .DEPTH(FIFO_DEPTH)) i_rx_fifo (
    .clk_i, .rst_ni,
    .push_i (rx_push),
    .data_i (rx_word),
    .pop_i  (rx_pop_i),
    .data_o (rx_data_o),
    .full_o (rx_full_o),
    .empty_o(rx_empty_o)
  );

  crsm_sclk_div #(.DIV_W(DIV_W)) i_div (
    .clk_i, .rst_ni,
    .run_i (run),
    .div_i (div_act),
    .tick_o(tick)
  );

  crsm_frame_ctrl #(
    .DIV_W(DIV_W), .RESP_MIN(RESP_MIN), .RESP_MAX(RESP_MAX), .LEN_W(LEN_W)
  ) i_ctrl (
    .clk_i, .rst_ni,
    .tx_empty_i(tx_empty_o),
    .tx_data_i (tx_head),
    .tx_pop_o  (tx_pop),
    .div_cfg_i (div_i),
    .len_cfg_i (resp_len_i),
    .cont_cfg_i(cont_i),
    .tick_i    (tick),
    .run_o     (run),
    .div_o     (div_act),
    .sdi_i,
    .sclk_o,
    .cs_no,
    .sdo_o,
    .busy_o,
    .rx_push_o (rx_push),
    .rx_word_o (rx_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  ovr_q <= 1'b0;
    else if (rx_push && rx_full_o) ovr_q <= 1'b1;
  end
  assign overrun_o = ovr_q;
endmodule

// File: rtl/crsm_checker.sv
module crsm_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic sclk_o,
  input logic cs_no,
  input logic sdo_o,
  input logic busy_o,
  input logic overrun_o,
  input logic tx_full_o,
  input logic tx_empty_o,
  input logic rx_full_o,
  input logic rx_empty_o
);
  assert_sclk_idle_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);

  assert_sdo_hold_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(sdo_o));

  assert_sdo_low_outside_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sdo_o);

  assert_cs_rise_after_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> !$past(sclk_o));

  assert_busy_tracks_cs_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == !cs_no);

  assert_tx_flags_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_full_o && tx_empty_o));

  assert_rx_flags_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_full_o && rx_empty_o));

  assert_overrun_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);
endmodule

bind cmd_reply_serial_master crsm_checker i_crsm_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sclk_o    (sclk_o),
  .cs_no     (cs_no),
  .sdo_o     (sdo_o),
  .busy_o    (busy_o),
  .overrun_o (overrun_o),
  .tx_full_o (tx_full_o),
  .tx_empty_o(tx_empty_o),
  .rx_full_o (rx_full_o),
  .rx_empty_o(rx_empty_o)
);

// File: tb/test_cmd_reply_serial_master.sv
module test_cmd_reply_serial_master;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int DEPTH = 8;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        tx_push_i = 1'b0, rx_pop_i = 1'b0, cont_i = 1'b0, sdi_i = 1'b0;
  logic [7:0]  tx_data_i = '0, div_i = 8'd1;
  logic [4:0]  resp_len_i = 5'd8;
  logic        tx_full_o, tx_empty_o, rx_full_o, rx_empty_o;
  logic [15:0] rx_data_o;
  logic        sclk_o, cs_no, sdo_o, busy_o, overrun_o;

  cmd_reply_serial_master i_cmd_reply_serial_master (.*);

  initial forever #2.5 clk_i = ~clk_i;

  int     compared = 0, mismatched = 0;
  longint cyc = 0;
  always @(posedge clk_i) cyc++;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  function automatic logic [15:0] reply_fn(input logic [7:0] c);
    return {c ^ 8'h5a, ~c};
  endfunction

  function automatic int clamp_len(input int v);
    return (v < 4) ? 4 : (v > 16) ? 16 : v;
  endfunction

  // reference model state
  logic [7:0]  cmd_q[$];
  int          exp_rx_q[$];
  bit          exp_ovr = 0, started = 0, first = 0;
  int          pos = 0, f_len = 8, f_div = 1, cs_rises = 0;
  logic [7:0]  cmd_sh = '0;
  logic [15:0] cur_reply = '0;
  longint      t_cs_fall = 0, t_last_rise = 0;

  always @(negedge cs_no) if (started) begin
    f_len     = clamp_len(int'(resp_len_i));
    f_div     = int'(div_i);
    t_cs_fall = cyc;
    pos       = 0;
    first     = 1;
  end

  always @(posedge cs_no) if (started) begin
    cs_rises++;
    chk(cyc - t_last_rise == longint'(2 * (f_div + 1)), "R6 cs rise delay",
        cyc - t_last_rise, 2 * (f_div + 1));
    pos = 0;
    #1 chk(!rx_empty_o, "R6 word queued at cs rise", rx_empty_o, 0);
  end

  always @(posedge sclk_o) begin
    logic [7:0] e;
    int         w;
    if (first) chk(cyc - t_cs_fall == longint'(f_div + 1), "R2 first rise",
                   cyc - t_cs_fall, f_div + 1);
    else       chk(cyc - t_last_rise == longint'(2 * (f_div + 1)), "R2 period",
                   cyc - t_last_rise, 2 * (f_div + 1));
    first       = 0;
    t_last_rise = cyc;
    if (pos < 8) cmd_sh = {cmd_sh[6:0], sdo_o};
    else chk(sdo_o == 1'b0, "R4 sdo low after command", sdo_o, 0);
    if (pos == 7) begin
      e = (cmd_q.size() > 0) ? cmd_q.pop_front() : 8'hxx;
      chk(cmd_sh === e, "R3 command bits", cmd_sh, e);
      cur_reply = reply_fn(cmd_sh);
    end
    if (pos == 8 + f_len) begin
      w = int'(cur_reply) & ((1 << f_len) - 1);
      if (exp_rx_q.size() < DEPTH) exp_rx_q.push_back(w);
      else exp_ovr = 1;
    end
    pos++;
    if (pos == 9 + f_len) pos = 0;
  end

  // slave: reply bits after falling edges, junk during command and idle period
  always @(negedge sclk_o) begin
    if (pos >= 9 && pos < 9 + f_len) sdi_i = cur_reply[f_len - 1 - (pos - 9)];
    else sdi_i = 1'($urandom);
  end

  task automatic push_byte(input logic [7:0] b);
    @(negedge clk_i);
    if (!tx_full_o) cmd_q.push_back(b);
    tx_data_i = b;
    tx_push_i = 1'b1;
    @(negedge clk_i);
    tx_push_i = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk_i);
    while (busy_o || !tx_empty_o) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
  endtask

  task automatic drain();
    int e;
    wait_idle();
    while (!rx_empty_o) begin
      e = (exp_rx_q.size() > 0) ? exp_rx_q.pop_front() : -1;
      chk(int'(rx_data_o) == e, "R5 reply word", rx_data_o, e);
      rx_pop_i = 1'b1;
      @(negedge clk_i);
      rx_pop_i = 1'b0;
      @(negedge clk_i);
    end
    chk(exp_rx_q.size() == 0, "R10 rx word count", exp_rx_q.size(), 0);
    chk(overrun_o == exp_ovr, "R11 overrun flag", overrun_o, exp_ovr);
  endtask

  task automatic cfg(input int d, input int l, input bit c);
    @(negedge clk_i);
    div_i      = 8'(d);
    resp_len_i = 5'(l);
    cont_i     = c;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    summary();
    $finish;
  end

  initial begin
    int r0;
    void'($urandom(32'd7719));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(cs_no == 1'b1 && sclk_o == 1'b0 && sdo_o == 1'b0, "R1 serial pins", {cs_no, sclk_o, sdo_o}, 3'b100);
    chk(!busy_o && !overrun_o, "R1 busy/overrun", {busy_o, overrun_o}, 0);
    chk(tx_empty_o && rx_empty_o && !tx_full_o && !rx_full_o, "R1 queue flags",
        {tx_empty_o, rx_empty_o, tx_full_o, rx_full_o}, 4'b1100);
    rst_ni = 1'b1;
    started = 1;

    // R8 busy follows the frame
    cfg(1, 8, 0);
    push_byte(8'ha5);
    repeat (2) @(negedge clk_i);
    chk(busy_o && !cs_no, "R8 busy during frame", {busy_o, cs_no}, 2'b10);
    drain();
    chk(!busy_o && cs_no, "R8 idle after frame", {busy_o, cs_no}, 2'b01);

    // R5 width extremes and clamping
    cfg(0, 4, 0);  push_byte(8'h3c); drain();
    cfg(2, 16, 0); push_byte(8'hc3); drain();
    cfg(1, 0, 0);  push_byte(8'h81); drain();
    cfg(0, 31, 0); push_byte(8'h7e); drain();

    // R7 continuous chain: one cs rise for three frames
    cfg(0, 6, 1);
    r0 = cs_rises;
    push_byte(8'h11); push_byte(8'h22); push_byte(8'h33);
    drain();
    chk(cs_rises - r0 == 1, "R7 cs held low across chain", cs_rises - r0, 1);

    // R9 config changes mid-frame are ignored
    cfg(2, 10, 0);
    r0 = cs_rises;
    push_byte(8'h5e);
    repeat (12) @(negedge clk_i);
    cfg(0, 4, 1);
    drain();
    chk(cs_rises - r0 == 1, "R9 frame ended per captured mode", cs_rises - r0, 1);

    // R10 tx full, R11 rx overrun
    cfg(1, 4, 0);
    for (int i = 0; i < 10; i++) push_byte(8'(8'h40 + i));
    chk(tx_full_o == 1'b1, "R10 tx full after 9 pushes", tx_full_o, 1);
    wait_idle();
    chk(rx_full_o == 1'b1, "R10 rx full", rx_full_o, 1);
    chk(overrun_o == 1'b1, "R11 overrun set", overrun_o, 1);
    drain();
    chk(overrun_o == 1'b1, "R11 overrun sticky after drain", overrun_o, 1);

    // random bursts
    for (int it = 0; it < 40; it++) begin
      int n;
      cfg(int'($urandom % 4), int'($urandom % 20), 1'($urandom));
      n = 1 + int'($urandom % 3);
      for (int k = 0; k < n; k++) push_byte(8'($urandom));
      drain();
    end

    chk(cmd_q.size() == 0, "R3 every queued command sent", cmd_q.size(), 0);
    summary();
    $finish;
  end
endmodule